// File: doc/BRIEF.md
# Digital LCD Segment Driver

This block drives a passive multiplexed LCD panel using only the two logic levels. No intermediate bias voltages are used. Each output pin has one of two roles. A common pin carries one of up to four backplane lines. A segment pin carries the data for the pixels that sit on its electrode. Time is divided into frames, and each frame has one slot for every active common. In each slot the common owning that slot is driven against the frame polarity. Segment pins are then driven either opposite to it (lit) or equal to it (unlit). The frame polarity flips at the end of every frame, so every pixel sees a zero DC average.

Two drive styles can be selected:

- **Correlation style.** Commons that are not active toggle on every time tick, and segments hold a static level for the whole slot.
- **Pulse-width style.** Each pin toggles inside a slot with a programmable duty cycle. The panel capacitance integrates these pulses.

A prescaler divides the clock down to the tick rate, and sixteen ticks make one slot. The segment data, the pin roles and the mode settings are captured into a shadow copy. This capture happens only at a frame boundary, or continuously while the block is disabled, so a displayed frame never mixes old and new data. When disabled, every pin sits at 0 and no pixel sees any voltage.

Top module: `lcd_seg_drv`

## Requirements
- R1: While reset (`rst_n` low, sampled at the clock edge) is applied, `pin_out` is all zeros and `frame_pol` is 0.
- R2: One clock after `enable` is sampled low, every bit of `pin_out` is 0. While disabled, the tick, phase, slot and polarity state return to zero.
- R3: A tick lasts `tick_div`+1 clocks, a slot lasts 16 ticks and a frame lasts `com_last`+1 slots. `frame_pol` inverts exactly once at each frame end and at no other time. The slot index never exceeds `com_last`.
- R4: In correlation mode (`use_pwm`=0), a common pin whose index in `role_idx` equals the current slot drives `frame_pol` for the whole slot.
- R5: In correlation mode, a common pin that is not active in the current slot drives `frame_pol` XOR bit 0 of the tick phase, so it toggles once per tick.
- R6: In correlation mode, a segment pin drives the inverse of `frame_pol` when its buffer bit for the current slot is 1, and drives `frame_pol` when that bit is 0.
- R7: In pulse-width mode (`use_pwm`=1), every pin drives `frame_pol` XOR (phase < d), where phase counts 0..15 within the slot. The value of d is:
  - 0 for the active common;
  - `duty_dark` for an inactive common;
  - `duty_lit` for a lit segment;
  - `duty_dark` for an unlit segment.
- R8: The data nibble of pin p sits at `seg_buf[4p+3:4p]`, so each 8-pin port occupies one 32-bit word. Bit k of the nibble belongs to common k. The 2-bit common index of pin p sits at `role_idx[2p+1:2p]`, and bit p of `role_com` set to 1 makes pin p a common.
- R9: Changes to `seg_buf`, `role_com`, `role_idx`, `com_last`, `use_pwm`, `duty_lit`, `duty_dark` and `tick_div` take effect only at the next frame end while enabled. While disabled they take effect immediately.
- R10: A common pin whose index is greater than `com_last` is never active and always drives the inactive-common waveform.
- R11: `pin_out` is registered. It shows the waveform value for the driver state that held one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Driver enable; low forces all pins to 0 |
| use_pwm | input | 1 | 0 = correlation style, 1 = pulse-width style |
| com_last | input | 2 | Number of active commons minus one |
| tick_div | input | PRE_W | Prescaler limit; tick = tick_div+1 clocks |
| duty_lit | input | 4 | Pulse-width duty for lit segments (phases out of 16) |
| duty_dark | input | 4 | Pulse-width duty for unlit segments and inactive commons |
| role_com | input | NPINS | Per-pin role, 1 = common |
| role_idx | input | 2*NPINS | Per-pin common index |
| seg_buf | input | 4*NPINS | Per-pin display nibbles, one 32-bit word per port |
| pin_out | output | NPINS | Pin levels |
| frame_pol | output | 1 | Current frame polarity |

## Verification
The checker watches four things on every clock: the flat output after a disable, the slot index bound, polarity changes occurring only at frame ends, and the frozen shadow data between frame ends. The exact per-pin waveforms are shown only by the bench's scenarios. These cover correlation and pulse-width levels, out-of-range common indices, mid-frame data and configuration writes, the frame length, and the duty corner values 0 and 15. The bench compares every pin against a behavioural model on every cycle.

// File: rtl/lcd_pkg.sv
// Shared constants and types for the digital LCD segment driver.
// Assumes at most four commons and sixteen phases per slot.
package lcd_pkg;
    localparam int COM_MAX       = 4;
    localparam int COM_IDX_W     = 2;
    localparam int SUB_W         = 4;
    localparam int PINS_PER_PORT = 8;
    localparam int NIB_W         = COM_MAX;

    typedef enum logic {
        DRIVE_CORR = 1'b0,
        DRIVE_PWM  = 1'b1
    } drive_style_e;
endpackage

// File: rtl/lcd_timebase.sv
// Prescaler, in-slot phase, slot index and frame polarity.
// Assumes div_lim and last_slot are held stable except at frame_end
// or while en is low (both come from the frame shadow).
module lcd_timebase
    import lcd_pkg::*;
#(
    parameter int PRE_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic [PRE_W-1:0]     div_lim,
    input  logic [COM_IDX_W-1:0] last_slot,
    output logic [PRE_W-1:0]     div_cnt,
    output logic [SUB_W-1:0]     phase,
    output logic [COM_IDX_W-1:0] slot,
    output logic                 pol,
    output logic                 frame_end
);
    localparam logic [SUB_W-1:0] PHASE_LAST = '1;

    logic tick;
    logic slot_end;

    // Decode tick, slot end and frame end from the counters.
    always_comb begin
        tick      = (div_cnt == div_lim);
        slot_end  = tick && (phase == PHASE_LAST);
        frame_end = en && slot_end && (slot == last_slot);
    end

    // Advance counters and flip polarity once per frame.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            div_cnt <= '0;
            phase   <= '0;
            slot    <= '0;
            pol     <= 1'b0;
        end else begin
            div_cnt <= tick ? '0 : div_cnt + PRE_W'(1);
            if (tick)
                phase <= phase + SUB_W'(1);
            if (slot_end)
                slot <= (slot == last_slot) ? '0 : slot + COM_IDX_W'(1);
            if (frame_end)
                pol <= ~pol;
        end
    end
endmodule

// File: rtl/lcd_frame_shadow.sv
// Generic load-enabled holding register for frame-synchronous settings.
// Assumes load is asserted at frame boundaries or while disabled.
module lcd_frame_shadow #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Capture the live settings only when allowed.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= d;
    end
endmodule

// File: rtl/lcd_pin_wave.sv
// Combinational waveform for one pin, either common or segment role.
// Assumes slot, phase and pol come from the shared timebase.
module lcd_pin_wave
    import lcd_pkg::*;
(
    input  logic                 en,
    input  logic                 is_com,
    input  logic [COM_IDX_W-1:0] com_sel,
    input  logic [NIB_W-1:0]     nibble,
    input  logic [COM_IDX_W-1:0] slot,
    input  logic [SUB_W-1:0]     phase,
    input  logic                 pol,
    input  drive_style_e         style,
    input  logic [SUB_W-1:0]     duty_on,
    input  logic [SUB_W-1:0]     duty_off,
    output logic                 level
);
    logic             active;
    logic             lit;
    logic [SUB_W-1:0] dsel;
    logic             wave;

    // Select the pin level from role, style and slot data.
    always_comb begin
        active = is_com && (com_sel == slot);
        lit    = nibble[slot];
        dsel   = '0;
        if (style == DRIVE_PWM) begin
            if (is_com)
                dsel = active ? '0 : duty_off;
            else
                dsel = lit ? duty_on : duty_off;
            wave = pol ^ (phase < dsel);
        end else if (is_com) begin
            wave = active ? pol : (pol ^ phase[0]);
        end else begin
            wave = lit ? ~pol : pol;
        end
        level = en & wave;
    end
endmodule

// File: rtl/lcd_seg_drv.sv
// Top of the digital LCD driver: frame shadow, timebase and one
// waveform generator per pin, with a registered output stage.
// Assumes the panel is wired so that each pin is a common or a segment.
module lcd_seg_drv
    import lcd_pkg::*;
#(
    parameter int NUM_PORTS = 2,
    parameter int PRE_W     = 8,
    localparam int NPINS    = NUM_PORTS * PINS_PER_PORT,
    localparam int DATA_W   = NPINS * NIB_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       enable,
    input  logic                       use_pwm,
    input  logic [COM_IDX_W-1:0]       com_last,
    input  logic [PRE_W-1:0]           tick_div,
    input  logic [SUB_W-1:0]           duty_lit,
    input  logic [SUB_W-1:0]           duty_dark,
    input  logic [NPINS-1:0]           role_com,
    input  logic [NPINS*COM_IDX_W-1:0] role_idx,
    input  logic [DATA_W-1:0]          seg_buf,
    output logic [NPINS-1:0]           pin_out,
    output logic                       frame_pol
);
    localparam int CFG_W = DATA_W + NPINS + NPINS * COM_IDX_W
                         + COM_IDX_W + 1 + 2 * SUB_W + PRE_W;

    logic [CFG_W-1:0]           cfg_live;
    logic [CFG_W-1:0]           cfg_q;
    logic [DATA_W-1:0]          q_buf;
    logic [NPINS-1:0]           q_role;
    logic [NPINS*COM_IDX_W-1:0] q_idx;
    logic [COM_IDX_W-1:0]       q_last;
    logic                       q_pwm;
    logic [SUB_W-1:0]           q_on;
    logic [SUB_W-1:0]           q_off;
    logic [PRE_W-1:0]           q_div;
    logic [PRE_W-1:0]           tb_div;
    logic [SUB_W-1:0]           tb_phase;
    logic [COM_IDX_W-1:0]       tb_slot;
    logic                       tb_pol;
    logic                       fe;
    logic [NPINS-1:0]           pin_d;

    assign cfg_live = {seg_buf, role_com, role_idx, com_last, use_pwm,
                       duty_lit, duty_dark, tick_div};
    assign {q_buf, q_role, q_idx, q_last, q_pwm, q_on, q_off, q_div} = cfg_q;

    lcd_frame_shadow #(.W(CFG_W)) u_shadow (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (!enable || fe),
        .d     (cfg_live),
        .q     (cfg_q)
    );

    lcd_timebase #(.PRE_W(PRE_W)) u_timebase (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (enable),
        .div_lim   (q_div),
        .last_slot (q_last),
        .div_cnt   (tb_div),
        .phase     (tb_phase),
        .slot      (tb_slot),
        .pol       (tb_pol),
        .frame_end (fe)
    );

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        lcd_pin_wave u_wave (
            .en       (enable),
            .is_com   (q_role[p]),
            .com_sel  (q_idx[p*COM_IDX_W +: COM_IDX_W]),
            .nibble   (q_buf[p*NIB_W +: NIB_W]),
            .slot     (tb_slot),
            .phase    (tb_phase),
            .pol      (tb_pol),
            .style    (drive_style_e'(q_pwm)),
            .duty_on  (q_on),
            .duty_off (q_off),
            .level    (pin_d[p])
        );
    end

    // Register the pin levels so the pads never see decode glitches.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pin_out <= '0;
        else
            pin_out <= pin_d;
    end

    assign frame_pol = tb_pol;
endmodule

// File: rtl/lcd_seg_drv_chk.sv
// Protocol checker for lcd_seg_drv, attached with bind below.
// Assumes it observes the top's internal timebase and shadow signals.
module lcd_seg_drv_chk #(
    parameter int NPINS  = 16,
    parameter int DATA_W = 64,
    parameter int PRE_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic [NPINS-1:0]  pin_out,
    input logic              frame_pol,
    input logic              frame_end,
    input logic [1:0]        slot,
    input logic [1:0]        last_slot_q,
    input logic [PRE_W-1:0]  div_cnt,
    input logic [PRE_W-1:0]  div_lim_q,
    input logic [DATA_W-1:0] buf_q
);
    p_flat_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (pin_out == '0));

    p_slot_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        slot <= last_slot_q);

    p_div_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        div_cnt <= div_lim_q);

    p_pol_frame_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !frame_end) |=> $stable(frame_pol));

    p_pol_flips_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && frame_end) |=> (frame_pol != $past(frame_pol)));

    p_buf_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !frame_end) |=> $stable(buf_q));
endmodule

bind lcd_seg_drv lcd_seg_drv_chk #(
    .NPINS  (NPINS),
    .DATA_W (DATA_W),
    .PRE_W  (PRE_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .pin_out     (pin_out),
    .frame_pol   (frame_pol),
    .frame_end   (fe),
    .slot        (tb_slot),
    .last_slot_q (q_last),
    .div_cnt     (tb_div),
    .div_lim_q   (q_div),
    .buf_q       (q_buf)
);

// File: tb/lcd_seg_drv_bench.sv
// Bench: behavioural frame model compared against the pins every clock.
module lcd_seg_drv_bench;
    localparam int NP = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic          use_pwm = 1'b0;
    logic [1:0]    com_last = 2'd3;
    logic [7:0]    tick_div = 8'd0;
    logic [3:0]    duty_lit = 4'd12;
    logic [3:0]    duty_dark = 4'd4;
    logic [NP-1:0] role_com = '0;
    logic [31:0]   role_idx = '0;
    logic [63:0]   seg_buf = '0;
    logic [NP-1:0] pin_out;
    logic          frame_pol;

    int checks = 0;
    int errors = 0;
    string ph = "R1";
    bit chk_on = 1'b0;

    // Model state
    int m_pcnt, m_phase, m_slot;
    bit m_pol;
    logic [63:0]   s_buf;
    logic [NP-1:0] s_com;
    logic [31:0]   s_idx;
    int s_last, s_on, s_off, s_div;
    bit s_pwm;
    logic [NP-1:0] exp_pin;
    string exp_tag [NP];

    always #5 clk = ~clk;

    lcd_seg_drv u_lcd_seg_drv (
        .clk(clk), .rst_n(rst_n), .enable(enable), .use_pwm(use_pwm),
        .com_last(com_last), .tick_div(tick_div), .duty_lit(duty_lit),
        .duty_dark(duty_dark), .role_com(role_com), .role_idx(role_idx),
        .seg_buf(seg_buf), .pin_out(pin_out), .frame_pol(frame_pol)
    );

    task automatic load_shadow();
        s_buf = seg_buf; s_com = role_com; s_idx = role_idx;
        s_last = int'(com_last); s_pwm = use_pwm;
        s_on = int'(duty_lit); s_off = int'(duty_dark); s_div = int'(tick_div);
    endtask

    function automatic bit model_pin(int p);
        int c, d;
        bit act, lit;
        if (s_com[p]) begin
            c = int'(s_idx[p*2 +: 2]);
            act = (c == m_slot);
            if (s_pwm) begin
                d = act ? 0 : s_off;
                return m_pol ^ (m_phase < d);
            end
            return act ? m_pol : (m_pol ^ ((m_phase % 2) == 1));
        end
        lit = s_buf[p*4 + m_slot];
        if (s_pwm) begin
            d = lit ? s_on : s_off;
            return m_pol ^ (m_phase < d);
        end
        return lit ? !m_pol : m_pol;
    endfunction

    function automatic string tag_of(int p);
        int c;
        if (!enable) return "R2";
        if (s_pwm) return "R7";
        if (s_com[p]) begin
            c = int'(s_idx[p*2 +: 2]);
            if (c > s_last) return "R10";
            return (c == m_slot) ? "R4" : "R5";
        end
        return "R6";
    endfunction

    // Reference model: output from the old state, then advance (R11).
    always @(posedge clk) begin
        bit fe;
        if (!rst_n) begin
            exp_pin = '0;
            m_pcnt = 0; m_phase = 0; m_slot = 0; m_pol = 0;
            s_buf = '0; s_com = '0; s_idx = '0; s_last = 0;
            s_pwm = 0; s_on = 0; s_off = 0; s_div = 0;
            for (int p = 0; p < NP; p++) exp_tag[p] = "R1";
        end else begin
            for (int p = 0; p < NP; p++) begin
                exp_pin[p] = enable ? model_pin(p) : 1'b0;
                exp_tag[p] = tag_of(p);
            end
            if (!enable) begin
                m_pcnt = 0; m_phase = 0; m_slot = 0; m_pol = 0;
                load_shadow();
            end else begin
                fe = (m_pcnt == s_div) && (m_phase == 15) && (m_slot == s_last);
                if (m_pcnt == s_div) begin
                    m_pcnt = 0;
                    if (m_phase == 15) begin
                        m_phase = 0;
                        m_slot = (m_slot == s_last) ? 0 : m_slot + 1;
                    end else m_phase++;
                end else m_pcnt++;
                if (fe) begin
                    m_pol = !m_pol;
                    load_shadow();
                end
            end
        end
    end

    // Per-cycle comparison of pins and polarity, away from the edge.
    always @(negedge clk) begin
        if (chk_on) begin
            checks++;
            if (pin_out !== exp_pin) begin
                errors++;
                for (int p = 0; p < NP; p++)
                    if (pin_out[p] !== exp_pin[p]) begin
                        $display("FAIL %s (scenario %s) pin %0d got %b expected %b",
                                 exp_tag[p], ph, p, pin_out[p], exp_pin[p]);
                        break;
                    end
            end
            checks++;
            if (frame_pol !== m_pol) begin
                errors++;
                $display("FAIL R3 (scenario %s) frame_pol got %b expected %b",
                         ph, frame_pol, m_pol);
            end
        end
    end

    task automatic chk(bit ok, string tag, string what, int got, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s got %0d expected %0d", tag, what, got, expv);
        end
    endtask

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        bit p0;
        run(3);
        // R1: reset state at the ports.
        chk(pin_out == '0, "R1", "pin_out under reset", int'(pin_out), 0);
        chk(frame_pol == 1'b0, "R1", "frame_pol under reset", int'(frame_pol), 0);
        rst_n = 1'b1;
        run(2);
        chk_on = 1'b1;

        // R4 R5 R6 R8: correlation, four commons on pins 0..3.
        ph = "R8";
        role_com = 16'h000F;
        role_idx = 32'h0000_00E4;
        seg_buf  = 64'h0123_4567_89AB_CDEF;
        enable = 1'b1;
        run(200);

        // R9: new data and config mid-frame, applied at the frame end.
        ph = "R9";
        run(7);
        seg_buf  = 64'hF0E1_D2C3_B4A5_9687;
        com_last = 2'd1;
        tick_div = 8'd2;
        run(300);

        // R10: commons indexed 2 and 3 lie beyond com_last=1.
        ph = "R10";
        role_com = 16'h100F;
        role_idx = 32'h0100_00E4;
        run(400);

        // R3: frame length with tick_div=1 and three commons.
        ph = "R3";
        tick_div = 8'd1;
        com_last = 2'd2;
        run(300);
        p0 = frame_pol;
        n = 0;
        while (frame_pol == p0 && n < 1000) begin run(1); n++; end
        p0 = frame_pol;
        n = 0;
        while (frame_pol == p0 && n < 1000) begin run(1); n++; end
        chk(n == 96, "R3", "frame length in clocks", n, 96);

        // R7: pulse-width mode, then duty corners 15 and 0.
        ph = "R7";
        use_pwm = 1'b1;
        tick_div = 8'd0;
        com_last = 2'd3;
        duty_lit = 4'd12;
        duty_dark = 4'd4;
        run(300);
        duty_lit = 4'd15;
        duty_dark = 4'd0;
        run(300);

        // R2: disable mid-frame, settings apply at once, re-enable.
        ph = "R2";
        run(9);
        enable = 1'b0;
        run(1);
        chk(pin_out == '0, "R2", "pin_out after disable", int'(pin_out), 0);
        use_pwm = 1'b0;
        seg_buf = 64'h5A5A_A5A5_3C3C_C3C3;
        run(5);
        enable = 1'b1;
        run(200);

        chk_on = 1'b0;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule